// File: doc/BRIEF.md
# Packed SIMD add/subtract unit

This block adds or subtracts two 64-bit operands that are read as a packed vector of equal-width elements. The element width can be 8, 16 or 32 bits, which gives 8, 4 or 2 independent lanes. Each operation is either signed or unsigned. On overflow, each lane either wraps around modulo its width or is clipped to the limit of its range.

The arithmetic is a single byte-sliced carry chain. The chain is cut at every lane boundary of the selected width. A per-byte clip stage then replaces a lane that overflowed with the matching limit value. One register stage follows, so the result shows up one cycle after issue. A guard input makes the issue conditional. When the guard is false, or when no valid is presented, the output register is not written, keeps its previous value, and the output valid stays low.

Top module: `simd_addsub`

## Requirements
- R1: The `esz_i` encoding is 0 for 8-bit lanes (8 lanes), 1 for 16-bit lanes (4 lanes) and 2 for 32-bit lanes (2 lanes). Code 3 behaves like code 2. Lane k takes bits [k*W+W-1 : k*W] of each operand and of the result.
- R2: With `clip_i`=0 and `sub_i`=0, each lane of the result is (a + b) mod 2^W. No carry passes into the next lane.
- R3: With `clip_i`=0 and `sub_i`=1, each lane of the result is (a - b) mod 2^W. It is formed as a plus the inverted b plus a carry-in of 1 per lane, and no borrow passes between lanes.
- R4: With `clip_i`=1 and `sgn_i`=1, a lane whose two's-complement result overflows becomes 0x7F.., the largest positive value, if a was non-negative. Otherwise it becomes 0x80.., the most negative value.
- R5: With `clip_i`=1 and `sgn_i`=0, an unsigned add that carries out of a lane gives all-ones. An unsigned subtract that borrows gives zero.
- R6: With `clip_i`=0, `sgn_i` has no effect on the result.
- R7: When `valid_i` and `guard_i` are both 1 at a clock edge, `valid_o` is 1 after that edge and `result_o` holds the result of that operation.
- R8: When `valid_i` or `guard_i` is 0 at a clock edge, `valid_o` is 0 after that edge and `result_o` keeps its previous value.
- R9: While `rst_ni` is low, `valid_o` is 0 and `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation presented this cycle |
| guard_i | input | 1 | Execution condition; 0 suppresses the write |
| esz_i | input | 2 | Element width select |
| sgn_i | input | 1 | 1 = signed elements, 0 = unsigned |
| clip_i | input | 1 | 1 = clip to range, 0 = wrap around |
| sub_i | input | 1 | 1 = a - b, 0 = a + b |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result written in the previous cycle |
| result_o | output | 64 | Registered result |

## Verification
In a single cycle, a lane boundary can cut a carry while the lane beside it saturates. If the clip stage took its overflow from the wrong byte, the neighbour would be clipped by mistake. The vectors put a carry-out or overflow in one lane next to lanes sitting exactly at their limits, at all three widths. Every lane of the result is compared against values worked out by hand. A suppressed issue can also arrive in the same cycle that the previous result is being presented. The bench checks that the held result is unchanged and that the output valid goes low.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    ESZ_B  = 2'd0,
    ESZ_H  = 2'd1,
    ESZ_W  = 2'd2,
    ESZ_WX = 2'd3
  } esz_e;

  // low byte-index bits that stay inside one lane
  function automatic logic [1:0] lane_mask(esz_e e);
    case (e)
      ESZ_B:   lane_mask = 2'd0;
      ESZ_H:   lane_mask = 2'd1;
      default: lane_mask = 2'd3;
    endcase
  endfunction

  function automatic logic lane_start(logic [1:0] bidx, esz_e e);
    lane_start = ((bidx & lane_mask(e)) == 2'd0);
  endfunction
endpackage

// File: rtl/simd_carry_chain.sv
module simd_carry_chain
  import simd_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0] a_i,
  input  logic [NB*8-1:0] b_i,
  input  esz_e            esz_i,
  input  logic            sub_i,
  output logic [NB*8-1:0] sum_o,
  output logic [NB-1:0]   cout_o,
  output logic [NB-1:0]   cmsb_o
);
  always_comb begin
    logic       c;
    logic       cin;
    logic [7:0] bx;
    logic [8:0] t;
    c = 1'b0;
    for (int k = 0; k < NB; k++) begin
      bx  = b_i[k*8 +: 8] ^ {8{sub_i}};
      cin = lane_start(2'(k), esz_i) ? sub_i : c;
      t   = {1'b0, a_i[k*8 +: 8]} + {1'b0, bx} + {8'd0, cin};
      sum_o[k*8 +: 8] = t[7:0];
      cout_o[k]       = t[8];
      cmsb_o[k]       = t[7] ^ a_i[k*8+7] ^ bx[7]; // carry into bit 7
      c               = t[8];
    end
  end
endmodule

// File: rtl/simd_clip.sv
module simd_clip
  import simd_pkg::*;
#(
  parameter int NB = 8
) (
  input  logic [NB*8-1:0] sum_i,
  input  logic [NB*8-1:0] a_i,
  input  logic [NB-1:0]   cout_i,
  input  logic [NB-1:0]   cmsb_i,
  input  esz_e            esz_i,
  input  logic            sgn_i,
  input  logic            clip_i,
  input  logic            sub_i,
  output logic [NB*8-1:0] res_o
);
  always_comb begin
    int         top;
    logic       ovf;
    logic       neg;
    logic [7:0] fill;
    for (int k = 0; k < NB; k++) begin
      top  = k | int'(lane_mask(esz_i));
      ovf  = sgn_i ? (cmsb_i[top] ^ cout_i[top]) : (cout_i[top] ^ sub_i);
      neg  = a_i[top*8+7];
      if (!sgn_i)   fill = sub_i ? 8'h00 : 8'hFF;
      else if (neg) fill = (k == top) ? 8'h80 : 8'h00;
      else          fill = (k == top) ? 8'h7F : 8'hFF;
      res_o[k*8 +: 8] = (clip_i && ovf) ? fill : sum_i[k*8 +: 8];
    end
  end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              guard_i,
  input  logic [1:0]        esz_i,
  input  logic              sgn_i,
  input  logic              clip_i,
  input  logic              sub_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int NB = DATA_W / 8;

  esz_e              esz;
  logic [DATA_W-1:0] sum;
  logic [NB-1:0]     cout;
  logic [NB-1:0]     cmsb;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;
  logic              valid_q;
  logic              wr_en;

  assign esz   = esz_e'(esz_i);
  assign wr_en = valid_i & guard_i;

  simd_carry_chain #(.NB(NB)) u_chain (
    .a_i    (a_i),
    .b_i    (b_i),
    .esz_i  (esz),
    .sub_i  (sub_i),
    .sum_o  (sum),
    .cout_o (cout),
    .cmsb_o (cmsb)
  );

  simd_clip #(.NB(NB)) u_clip (
    .sum_i  (sum),
    .a_i    (a_i),
    .cout_i (cout),
    .cmsb_i (cmsb),
    .esz_i  (esz),
    .sgn_i  (sgn_i),
    .clip_i (clip_i),
    .sub_i  (sub_i),
    .res_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= wr_en;
      if (wr_en) res_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  AST_ISSUE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && guard_i |=> valid_o); // R7
  AST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && guard_i) |=> !valid_o && $stable(result_o)); // R8

  for (genvar g = 0; g < NB; g++) begin : g_byte_chk
    AST_WRAP_ADD_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && guard_i && !clip_i && !sub_i && esz_i == 2'd0
      |=> result_o[g*8 +: 8] == 8'($past(a_i[g*8 +: 8]) + $past(b_i[g*8 +: 8]))); // R2
    AST_UNS_ADD_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && guard_i && clip_i && !sgn_i && !sub_i && esz_i == 2'd0
      |=> result_o[g*8 +: 8] >= $past(a_i[g*8 +: 8])); // R5
    AST_UNS_SUB_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && guard_i && clip_i && !sgn_i && sub_i && esz_i == 2'd0
      |=> result_o[g*8 +: 8] <= $past(a_i[g*8 +: 8])); // R5
    AST_SGN_POS_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && guard_i && clip_i && sgn_i && !sub_i && esz_i == 2'd0
      && !a_i[g*8+7] && !b_i[g*8+7]
      |=> !result_o[g*8+7]); // R4
  end
endmodule

// File: tb/simd_addsub_bench.sv
module simd_addsub_bench;
  typedef struct packed {
    logic [1:0]  esz;
    logic        sgn;
    logic        clip;
    logic        sub;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 64'h00FF_7F80_1234_FFFF, 64'h0001_0180_0101_0001, 64'h0000_8000_1335_FF00},
    '{2'd1, 1'b0, 1'b0, 1'b0, 64'h00FF_7F80_1234_FFFF, 64'h0001_0180_0101_0001, 64'h0100_8100_1335_0000},
    '{2'd2, 1'b0, 1'b0, 1'b0, 64'h00FF_7F80_1234_FFFF, 64'h0001_0180_0101_0001, 64'h0100_8100_1336_0000},
    '{2'd0, 1'b0, 1'b1, 1'b0, 64'h00FF_7F80_1234_FFFF, 64'h0001_0180_0101_0001, 64'h00FF_80FF_1335_FFFF},
    '{2'd0, 1'b1, 1'b1, 1'b0, 64'h00FF_7F80_1234_FFFF, 64'h0001_0180_0101_0001, 64'h0000_7F80_1335_FF00},
    '{2'd0, 1'b1, 1'b0, 1'b0, 64'h00FF_7F80_1234_FFFF, 64'h0001_0180_0101_0001, 64'h0000_8000_1335_FF00},
    '{2'd0, 1'b0, 1'b0, 1'b1, 64'h0010_0080_7F00_05FF, 64'h0001_0100_8001_0601, 64'h000F_FF80_FFFF_FFFE},
    '{2'd0, 1'b0, 1'b1, 1'b1, 64'h0010_0080_7F00_05FF, 64'h0001_0100_8001_0601, 64'h000F_0080_0000_00FE},
    '{2'd0, 1'b1, 1'b1, 1'b1, 64'h0010_0080_7F00_05FF, 64'h0001_0100_8001_0601, 64'h000F_FF80_7FFF_FFFE},
    '{2'd1, 1'b1, 1'b1, 1'b0, 64'h7FFF_8000_0001_FFFF, 64'h0001_FFFF_7FFF_0001, 64'h7FFF_8000_7FFF_0000},
    '{2'd2, 1'b0, 1'b1, 1'b1, 64'h0000_0005_8000_0000, 64'h0000_0006_7FFF_FFFF, 64'h0000_0000_0000_0001},
    '{2'd2, 1'b1, 1'b1, 1'b1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 64'h8000_0000_7FFF_FFFF},
    '{2'd2, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd1, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_FFFF},
    '{2'd3, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_FFFF}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 2:         tag_of = "R2";
      3, 7, 10, 12:    tag_of = "R5";
      4, 8, 9, 11:     tag_of = "R4";
      5:               tag_of = "R6";
      6, 13:           tag_of = "R3";
      default:         tag_of = "R1";
    endcase
  endfunction

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        guard = 1'b0;
  logic [1:0]  esz = 2'd0;
  logic        sgn = 1'b0;
  logic        clip = 1'b0;
  logic        sub = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        valid_o;
  logic [63:0] result_o;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  simd_addsub u_simd_addsub (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .valid_i  (valid),
    .guard_i  (guard),
    .esz_i    (esz),
    .sgn_i    (sgn),
    .clip_i   (clip),
    .sub_i    (sub),
    .a_i      (a),
    .b_i      (b),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int i, logic v, logic g);
    valid = v;
    guard = g;
    esz   = VECS[i].esz;
    sgn   = VECS[i].sgn;
    clip  = VECS[i].clip;
    sub   = VECS[i].sub;
    a     = VECS[i].a;
    b     = VECS[i].b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {63'd0, valid_o}, 64'd0);
    chk("R9 reset result", result_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, one issue then one idle cycle each
    for (int i = 0; i < NV; i++) begin
      drive(i, 1'b1, 1'b1);
      @(negedge clk);
      chk({tag_of(i), " result"}, result_o, VECS[i].exp);
      chk("R7 valid", {63'd0, valid_o}, 64'd1);
      valid = 1'b0;
      @(negedge clk);
    end

    // back-to-back issue
    drive(3, 1'b1, 1'b1);
    @(negedge clk);
    drive(9, 1'b1, 1'b1);
    chk("R7 b2b first", result_o, VECS[3].exp);
    @(negedge clk);
    // guard false in the cycle the previous result is shown
    drive(0, 1'b1, 1'b0);
    chk("R7 b2b second", result_o, VECS[9].exp);
    chk("R7 b2b valid", {63'd0, valid_o}, 64'd1);
    @(negedge clk);
    chk("R8 guard low valid", {63'd0, valid_o}, 64'd0);
    chk("R8 guard low held", result_o, VECS[9].exp);
    drive(1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 no valid", {63'd0, valid_o}, 64'd0);
    chk("R8 no valid held", result_o, VECS[9].exp);

    // async reset mid-run
    drive(12, 1'b1, 1'b1);
    @(negedge clk);
    valid = 1'b0;
    chk("R5 pre-reset", result_o, VECS[12].exp);
    #1 rst_n = 1'b0;
    #1;
    chk("R9 async valid", {63'd0, valid_o}, 64'd0);
    chk("R9 async result", result_o, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule